// File: doc/BRIEF.md
# Level-Flagged Synchronous FIFO

A single-clock first-in first-out buffer with a parameterised word width and a power-of-two storage depth D. It reports five registered status flags, all active-low: empty, almost-empty, half-full, almost-full and full. Two offsets live inside the block: a near-empty margin n and a near-full margin m. While reset is held, a load-mode strap fixes how these offsets are written later and what they start at. A second strap fixes the output behaviour. In standard mode, a word comes out one cycle after it is requested. In first-word-fall-through mode, the head word waits in an output register and the capacity grows to D+1.

Data moves on two valid/ready streams. On the write side, `in_ready` is the inverse of full. A beat transfers when `in_valid` and `in_ready` are both high. A beat offered while full is dropped. On the read side in standard mode, `out_ready` is a read request. It is honoured only when the FIFO is not empty, and the word appears on `out_data` with a one-cycle `out_valid` pulse on the following cycle. In first-word-fall-through mode, `out_valid` stays high while a head word is presented. That word leaves when `out_valid` and `out_ready` are both high, and it is held steady while `out_ready` is low.

The offsets can be rewritten at any time after reset through a small programming port. They are read back on a parallel bus, whatever load mode is in force.

Top module: `lvl_fifo`

## Requirements
- R1: While `rst_n` is low, `ld_strap` and `fwft_strap` are sampled, and the values they hold at release stay in force until the next reset. A high `ld_strap` selects serial offset loading and presets both offsets to 1023. A low `ld_strap` selects parallel loading and presets both to 127. A high `fwft_strap` selects first-word-fall-through mode.
- R2: In parallel mode, each `ofs_we` cycle writes `ofs_wdata` to one offset. The first write after reset goes to n, the second to m, and the target keeps alternating after that.
- R3: In serial mode, each `ofs_we` cycle shifts `ofs_sdata` into a 2×OFS_W-bit chain and `ofs_wdata` has no effect. After 2×OFS_W shifts, the first OFS_W bits form n, least significant bit first, and the last OFS_W bits form m in the same order.
- R4: `ofs_rdata` shows n while the read selector is clear and m while it is set. Each `ofs_re` cycle flips the selector. Reset clears the selector, and offset writes do not move it.
- R5: Words leave in the order they were accepted. In standard mode, a read accepted at an edge gives `out_valid` high with the word on `out_data` for the following cycle only.
- R6: In first-word-fall-through mode, the head word is presented with `out_valid` high and leaves on a cycle where `out_ready` is also high. The FIFO accepts D+1 words before it reports full.
- R7: `empty_n` is low exactly at 0 words. `full_n` is low exactly at D words in standard mode, or D+1 words in first-word-fall-through mode.
- R8: `aempty_n` is low when the word count is at most n in standard mode, or at most n+1 in first-word-fall-through mode.
- R9: `half_n` is low when the word count is at least D/2+1 in standard mode, or at least D/2+2 in first-word-fall-through mode.
- R10: `afull_n` is low when the word count is at least D−m in standard mode, or at least D+1−m in first-word-fall-through mode.
- R11: `in_ready` is low whenever the FIFO is full, and a write offered then leaves the contents unchanged. A standard-mode read request while empty produces no `out_valid`.
- R12: A write and a read accepted at the same edge leave the word count, and so every flag, unchanged.
- R13: Each flag changes on the same clock edge as the write or read that moves the count across its threshold. After reset, the flags show empty and almost-empty low and the other three high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low master reset |
| ld_strap | input | 1 | Offset load mode strap, sampled in reset (1 = serial) |
| fwft_strap | input | 1 | Output mode strap, sampled in reset (1 = fall-through) |
| in_valid | input | 1 | Write beat offered |
| in_ready | output | 1 | Space available (not full) |
| in_data | input | DATA_W | Write word |
| out_valid | output | 1 | Read word present on out_data |
| out_ready | input | 1 | Read request / consumer ready |
| out_data | output | DATA_W | Read word |
| ofs_we | input | 1 | Offset write strobe or shift enable |
| ofs_sdata | input | 1 | Serial offset bit |
| ofs_wdata | input | OFS_W | Parallel offset value |
| ofs_re | input | 1 | Advance the readback selector |
| ofs_rdata | output | OFS_W | Offset readback |
| full_n | output | 1 | Full, active-low |
| afull_n | output | 1 | Almost-full, active-low |
| half_n | output | 1 | Half-full, active-low |
| aempty_n | output | 1 | Almost-empty, active-low |
| empty_n | output | 1 | Empty, active-low |

## Verification
A write and a read can land on the same edge. When they do, the count must stay where it is, and the flags must be judged against that unchanged count rather than against either operation on its own. Random stimulus with a fixed seed keeps both streams active at once in both output modes. Directed steps add a simultaneous write and read halfway through the buffer, and a write combined with a read while the buffer is full. A bench model of the queue and its count predicts every flag on every cycle and every word that comes out.

// File: rtl/lvl_fifo_pkg.sv
package lvl_fifo_pkg;
  typedef struct packed {
    logic full_n;
    logic afull_n;
    logic half_n;
    logic aempty_n;
    logic empty_n;
  } lvl_flags_t;
endpackage

// File: rtl/lvl_fifo_ofs.sv
// Offset registers: strap-selected defaults, serial chain or toggled parallel
// writes, and a toggled parallel readback.
module lvl_fifo_ofs #(
  parameter int OFS_W   = 10,
  parameter int SER_DEF = 1023,
  parameter int PAR_DEF = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_strap,
  input  logic             we,
  input  logic             sdata,
  input  logic [OFS_W-1:0] wdata,
  input  logic             re,
  output logic [OFS_W-1:0] rdata,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  localparam int CHW = 2 * OFS_W;

  logic           ser_q;
  logic           wsel_q;
  logic           rsel_q;
  logic [CHW-1:0] chain_q;

  // chain layout: low half = near-empty margin, high half = near-full margin
  assign ae_ofs = chain_q[OFS_W-1:0];
  assign af_ofs = chain_q[CHW-1:OFS_W];
  assign rdata  = rsel_q ? af_ofs : ae_ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q   <= ld_strap;
      wsel_q  <= 1'b0;
      rsel_q  <= 1'b0;
      chain_q <= ld_strap ? {OFS_W'(SER_DEF), OFS_W'(SER_DEF)}
                          : {OFS_W'(PAR_DEF), OFS_W'(PAR_DEF)};
    end else begin
      if (we) begin
        if (ser_q) begin
          // new bit enters at the top; after CHW shifts the first bit is at 0
          chain_q <= {sdata, chain_q[CHW-1:1]};
        end else begin
          if (wsel_q) chain_q[CHW-1:OFS_W] <= wdata;
          else        chain_q[OFS_W-1:0]   <= wdata;
          wsel_q <= ~wsel_q;
        end
      end
      if (re) rsel_q <= ~rsel_q;
    end
  end
endmodule

// File: rtl/lvl_fifo_store.sv
// Circular storage, pointers and the output register for both read modes.
module lvl_fifo_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwft,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              take
);
  localparam int AW = $clog2(DEPTH);
  localparam int RW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [RW-1:0]     ram_cnt_q;
  logic              ov_q;
  logic [DATA_W-1:0] od_q;
  logic              ram_nz;
  logic              ram_pop;

  assign ram_nz = (ram_cnt_q != '0);

  always_comb begin
    if (fwft) begin
      take    = ov_q & out_ready;
      ram_pop = ram_nz & (~ov_q | take);
    end else begin
      take    = out_ready & ram_nz;
      ram_pop = take;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q      <= '0;
      rp_q      <= '0;
      ram_cnt_q <= '0;
      ov_q      <= 1'b0;
      od_q      <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (ram_pop) begin
        rp_q <= rp_q + 1'b1;
        od_q <= mem[rp_q];
      end
      ram_cnt_q <= ram_cnt_q + RW'(push) - RW'(ram_pop);
      ov_q      <= fwft ? (ram_pop | (ov_q & ~take)) : ram_pop;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
endmodule

// File: rtl/lvl_fifo_level.sv
// Word count and registered flag decode from the next-state count.
module lvl_fifo_level
  import lvl_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int OFS_W = 10,
  parameter int CW    = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwft,
  input  logic             push,
  input  logic             pop,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  output logic [CW-1:0]    cnt,
  output lvl_flags_t       flags
);
  localparam int XW = ((CW > OFS_W) ? CW : OFS_W) + 2;

  logic [CW-1:0] cnt_n;
  logic [XW-1:0] cx, ext;
  lvl_flags_t    nf;

  always_comb begin
    cnt_n       = cnt + CW'(push) - CW'(pop);
    cx          = XW'(cnt_n);
    ext         = XW'(fwft);
    nf.empty_n  = (cnt_n != '0);
    nf.aempty_n = !(cx <= XW'(ae_ofs) + ext);
    nf.half_n   = !(cx >= XW'(DEPTH / 2 + 1) + ext);
    nf.afull_n  = !(cx + XW'(af_ofs) >= XW'(DEPTH) + ext);
    nf.full_n   = !(cx == XW'(DEPTH) + ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt            <= '0;
      flags.full_n   <= 1'b1;
      flags.afull_n  <= 1'b1;
      flags.half_n   <= 1'b1;
      flags.aempty_n <= 1'b0;
      flags.empty_n  <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      flags <= nf;
    end
  end
endmodule

// File: rtl/lvl_fifo.sv
// Top: strap capture, stream edges and wiring of storage, count and offsets.
module lvl_fifo
  import lvl_fifo_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 1024,
  parameter int OFS_W   = 10,
  parameter int SER_DEF = 1023,
  parameter int PAR_DEF = 127
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_strap,
  input  logic              fwft_strap,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              ofs_we,
  input  logic              ofs_sdata,
  input  logic [OFS_W-1:0]  ofs_wdata,
  input  logic              ofs_re,
  output logic [OFS_W-1:0]  ofs_rdata,
  output logic              full_n,
  output logic              afull_n,
  output logic              half_n,
  output logic              aempty_n,
  output logic              empty_n
);
  localparam int CW = $clog2(DEPTH + 2);

  logic             fwft_q;
  logic             push;
  logic             take;
  logic [CW-1:0]    cnt_q;
  logic [OFS_W-1:0] ae_ofs, af_ofs;
  lvl_flags_t       flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwft_q <= fwft_strap;
  end

  assign in_ready = flags.full_n;
  assign push     = in_valid & flags.full_n;

  lvl_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .fwft(fwft_q), .push(push), .wdata(in_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .take(take)
  );

  lvl_fifo_level #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CW(CW)) u_level (
    .clk(clk), .rst_n(rst_n), .fwft(fwft_q), .push(push), .pop(take),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .cnt(cnt_q), .flags(flags)
  );

  lvl_fifo_ofs #(.OFS_W(OFS_W), .SER_DEF(SER_DEF), .PAR_DEF(PAR_DEF)) u_ofs (
    .clk(clk), .rst_n(rst_n), .ld_strap(ld_strap), .we(ofs_we), .sdata(ofs_sdata),
    .wdata(ofs_wdata), .re(ofs_re), .rdata(ofs_rdata), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  assign full_n   = flags.full_n;
  assign afull_n  = flags.afull_n;
  assign half_n   = flags.half_n;
  assign aempty_n = flags.aempty_n;
  assign empty_n  = flags.empty_n;
endmodule

// File: rtl/lvl_fifo_chk.sv
module lvl_fifo_chk #(
  parameter int DEPTH = 1024,
  parameter int CW    = $clog2(DEPTH + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          empty_n,
  input logic          full_n,
  input logic          aempty_n,
  input logic          fwft_q,
  input logic [CW-1:0] cnt_q
);
  logic [CW-1:0] cap;
  assign cap = fwft_q ? CW'(DEPTH + 1) : CW'(DEPTH);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (cnt_q < cap));
  p_empty_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty_n == (cnt_q != '0));
  p_full_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_n == (cnt_q != cap));
  p_count_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));
  p_ae_at_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
  p_std_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft_q && out_valid) |-> $past(out_ready && empty_n));
  p_fwft_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft_q && $past(out_valid && !out_ready)) |-> out_valid);
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(fwft_q));
endmodule

bind lvl_fifo lvl_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .empty_n(empty_n),
  .full_n(full_n), .aempty_n(aempty_n), .fwft_q(fwft_q), .cnt_q(cnt_q)
);

// File: tb/lvl_fifo_bench.sv
module lvl_fifo_bench;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1024;
  localparam int OFS_W  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_strap = 1'b0, fwft_strap = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DATA_W-1:0] out_data;
  logic ofs_we = 1'b0, ofs_sdata = 1'b0, ofs_re = 1'b0;
  logic [OFS_W-1:0] ofs_wdata = '0;
  logic [OFS_W-1:0] ofs_rdata;
  logic full_n, afull_n, half_n, aempty_n, empty_n;

  always #2 clk = ~clk;

  lvl_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OFS_W(OFS_W)) u_lvl_fifo (
    .clk(clk), .rst_n(rst_n), .ld_strap(ld_strap), .fwft_strap(fwft_strap),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ofs_we(ofs_we), .ofs_sdata(ofs_sdata), .ofs_wdata(ofs_wdata),
    .ofs_re(ofs_re), .ofs_rdata(ofs_rdata), .full_n(full_n), .afull_n(afull_n),
    .half_n(half_n), .aempty_n(aempty_n), .empty_n(empty_n)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  int q[$];
  int m_n, m_m;
  bit m_fwft;
  bit exp_v;
  int exp_d;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit [4:0] exp_flags(int c);
    int e = m_fwft ? 1 : 0;
    bit f, af, hf, ae, em;
    f  = (c == DEPTH + e);
    af = (c >= DEPTH + e - m_m);
    hf = (c >= DEPTH / 2 + 1 + e);
    ae = (c <= m_n + e);
    em = (c == 0);
    return {!f, !af, !hf, !ae, !em};
  endfunction

  task automatic flag_check();
    bit [4:0] ef = exp_flags(q.size());
    chk("R7/R13 full_n", full_n, ef[4]);
    chk("R10/R13 afull_n", afull_n, ef[3]);
    chk("R9/R13 half_n", half_n, ef[2]);
    chk("R8/R13 aempty_n", aempty_n, ef[1]);
    chk("R7/R13 empty_n", empty_n, ef[0]);
    chk("R11 in_ready", in_ready, ef[4]);
  endtask

  // one cycle of traffic; called just after a falling edge
  task automatic step(bit wv, int wd, bit rr);
    bit push, pop;
    in_valid  = wv;
    in_data   = DATA_W'(wd);
    out_ready = rr;
    push = wv && in_ready;
    exp_v = 0;
    if (m_fwft) begin
      pop = out_valid && rr;
      if (pop) begin
        chk("R6 head word", out_data, q[0]);
        void'(q.pop_front());
      end
    end else begin
      pop = rr && (q.size() > 0);
      if (pop) begin
        exp_v = 1;
        exp_d = q.pop_front();
      end
    end
    if (push) q.push_back(wd & 8'hFF);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    out_ready = 0;
    flag_check();
    if (m_fwft) begin
      if (q.size() == 0) chk("R6 no word when empty", out_valid, 0);
    end else begin
      chk("R5/R11 out_valid pulse", out_valid, exp_v);
      if (exp_v) chk("R5 order", out_data, exp_d);
    end
  endtask

  task automatic do_reset(bit ld, bit ff);
    ld_strap = ld;
    fwft_strap = ff;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    ld_strap = ~ld;
    fwft_strap = ~ff;
    q.delete();
    m_fwft = ff;
    m_n = ld ? 1023 : 127;
    m_m = m_n;
    @(negedge clk);
  endtask

  task automatic pulse_re();
    ofs_re = 1;
    @(posedge clk);
    @(negedge clk);
    ofs_re = 0;
  endtask

  task automatic par_write(int v);
    ofs_we = 1;
    ofs_wdata = OFS_W'(v);
    @(posedge clk);
    @(negedge clk);
    ofs_we = 0;
  endtask

  task automatic ser_load(int n, int m);
    for (int i = 0; i < 2 * OFS_W; i++) begin
      ofs_we = 1;
      ofs_sdata = (i < OFS_W) ? n[i] : m[i - OFS_W];
      ofs_wdata = OFS_W'($urandom);
      @(posedge clk);
      @(negedge clk);
    end
    ofs_we = 0;
  endtask

  task automatic random_run(int n, int wp, int rp);
    for (int i = 0; i < n; i++)
      step(($urandom % 100) < wp, $urandom % 256, ($urandom % 100) < rp);
  endtask

  task automatic fill_to_full();
    for (int i = 0; i < DEPTH + 4 && in_ready; i++) step(1, $urandom % 256, 0);
  endtask

  task automatic traffic();
    int sz;
    bit h;
    random_run(1600, 90, 20);
    fill_to_full();
    chk("R6/R7 capacity", q.size(), m_fwft ? DEPTH + 1 : DEPTH);
    sz = q.size();
    step(1, 8'h5A, 0);
    chk("R11 write while full ignored", q.size(), sz);
    chk("R11 in_ready low", in_ready, 0);
    step(1, 8'h3C, 1);
    while (q.size() > DEPTH / 2) step(0, 0, 1);
    sz = q.size();
    h = half_n;
    step(1, 8'hC3, 1);
    chk("R12 count kept", q.size(), sz);
    chk("R12 half_n kept", half_n, h);
    random_run(1800, 20, 90);
    while (q.size() > 0) step(0, 0, 1);
    step(0, 0, 1);
    chk("R11 empty read", empty_n, 0);
    random_run(600, 50, 50);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // standard mode, parallel offsets
    do_reset(1'b0, 1'b0);
    chk("R13 reset empty_n", empty_n, 0);
    chk("R13 reset aempty_n", aempty_n, 0);
    chk("R13 reset half_n", half_n, 1);
    chk("R13 reset afull_n", afull_n, 1);
    chk("R13 reset full_n", full_n, 1);
    chk("R13 reset out_valid", out_valid, 0);
    chk("R1 parallel default n", ofs_rdata, 127);
    pulse_re();
    chk("R1 parallel default m", ofs_rdata, 127);
    pulse_re();
    par_write(5);
    chk("R2/R4 n written first", ofs_rdata, 5);
    par_write(6);
    chk("R2 n kept after second write", ofs_rdata, 5);
    pulse_re();
    chk("R2/R4 m written second", ofs_rdata, 6);
    pulse_re();
    chk("R4 selector back to n", ofs_rdata, 5);
    m_n = 5;
    m_m = 6;
    traffic();

    // fall-through mode, serial offsets
    do_reset(1'b1, 1'b1);
    chk("R1 serial default n", ofs_rdata, 1023);
    pulse_re();
    chk("R1 serial default m", ofs_rdata, 1023);
    pulse_re();
    ser_load(9, 3);
    chk("R3 serial n", ofs_rdata, 9);
    pulse_re();
    chk("R3 serial m", ofs_rdata, 3);
    pulse_re();
    m_n = 9;
    m_m = 3;
    traffic();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule